// File: doc/BRIEF.md
# Atomic Swap Instruction Unit

This unit takes a 32-bit instruction word from the atomic swap family and carries out the swap against a single memory port. It decodes the operand fields, reads two registers through combinational read ports, reads the old word or doubleword at the base address, writes the store operand back to that same address, and returns the old value through a register write port. The memory port stays locked from the read request until the write response, so no other requester can get in between.

The instruction enters through a valid/ready handshake. `insn_ready` is high only while the unit is idle, and a word is taken on a clock edge where both `insn_valid` and `insn_ready` are high. The memory request channel is also valid/ready. Once `mem_req_valid` is raised, it and the request fields stay unchanged until `mem_req_ready` is seen high. Each accepted request gets exactly one `mem_rsp_valid` pulse in a later cycle. The unit accepts responses at any time, so the response channel has no ready signal.

The register read ports are combinational. The indices are driven from `insn_word` in the idle state, and `rs_data` and `rn_data` must be valid in that same cycle.

Top module: `atomic_swap_unit`

## Requirements
- R1: A word is legal only if bit 31 is 1, bits 29:24 are 111000, bit 21 is 1 and bits 15:10 are 100000. An illegal word gives a done pulse with `undef_insn` high, makes no memory request and does not write a register.
- R2: Bit 30 selects the access size. When it is 0 the access is a 32-bit word, and when it is 1 the access is a 64-bit doubleword. `mem_req_dword` shows the size on every request.
- R3: At done, `rel_flag` equals bit 22. `acq_flag` is 1 only when bit 23 is 1 and the destination index (bits 4:0) is not 31.
- R4: The base index is bits 9:5. If it is 31, the address is `sp_value`; otherwise the address is register `rn_data`. At done, `tag_chk` is 1 exactly when the base index is not 31.
- R5: If the stack pointer is the base and its low 4 bits are not zero, the done pulse carries `align_fault` high, no memory request is made and no register is written.
- R6: The write data is register Rs (index in bits 20:16). For a word access, bits 63:32 of `mem_wdata` are zero.
- R7: For a legal access, the value read is returned on `rd_data` with `rd_we` high and `rd_idx` equal to bits 4:0. A word result is zero-extended: bits 63:32 are 0 whatever the memory returns in its upper half.
- R8: When the destination index is 31, `rd_we` stays low, but the memory write still takes place.
- R9: A legal access makes exactly one read and then one write to the same address. `mem_lock` is high from the read request through the write response.
- R10: `done` is a single-cycle pulse, and the result and all flags are valid in that cycle. No memory request is made while `insn_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction word offered |
| insn_ready | output | 1 | Unit idle and able to take a word |
| insn_word | input | 32 | Instruction word |
| rs_idx | output | 5 | Index of the store-operand register |
| rs_data | input | 64 | Contents of register `rs_idx` |
| rn_idx | output | 5 | Index of the base register |
| rn_data | input | 64 | Contents of register `rn_idx` |
| sp_value | input | 64 | Current stack pointer |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 for a write, 0 for a read |
| mem_req_dword | output | 1 | 1 for a 64-bit access, 0 for a 32-bit access |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 64 | Write data |
| mem_lock | output | 1 | Keep other requesters off the port |
| mem_rsp_valid | input | 1 | Response to the oldest request |
| mem_rdata | input | 64 | Read data (the low 32 bits are used for a word access) |
| done | output | 1 | Completion pulse |
| rd_we | output | 1 | Destination register write enable |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | 64 | Old memory value, zero-extended |
| acq_flag | output | 1 | Acquire ordering requested |
| rel_flag | output | 1 | Release ordering requested |
| tag_chk | output | 1 | Tag check requested |
| align_fault | output | 1 | Stack-pointer alignment fault |
| undef_insn | output | 1 | Word is not a swap encoding |

## Verification
The assertions assume that the memory side keeps the protocol: it sends exactly one response for each accepted request, and never sends a response when nothing is outstanding. They also assume that the register ports return data in the cycle the index is driven. The bench's memory model gives a single response one cycle after each accepted request, and it randomises only `mem_req_ready`. Base addresses are kept within a small modelled window and aligned to the access size, so each expected value is known from the model.

// File: rtl/asu_pkg.sv
package asu_pkg;
  localparam int IDXW = 5;
  localparam logic [IDXW-1:0] ZR_IDX = '1;

  typedef struct packed {
    logic            legal;
    logic            dword;
    logic            acq;
    logic            rel;
    logic            sp_base;
    logic [IDXW-1:0] rs;
    logic [IDXW-1:0] rn;
    logic [IDXW-1:0] rt;
  } swap_dec_t;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_REQ, S_RD_WAIT, S_WR_REQ, S_WR_WAIT, S_DONE
  } swap_state_e;
endpackage

// File: rtl/asu_decode.sv
module asu_decode
  import asu_pkg::*;
(
  input  logic [31:0] word,
  output swap_dec_t   dec
);
  logic fixed_ok;

  always_comb begin
    fixed_ok = word[31] && (word[29:24] == 6'b111000) && word[21]
               && (word[15:10] == 6'b100000);
    dec.legal   = fixed_ok;
    dec.dword   = word[30];
    dec.rs      = word[20:16];
    dec.rn      = word[9:5];
    dec.rt      = word[4:0];
    dec.rel     = word[22];
    dec.acq     = word[23] && (word[4:0] != ZR_IDX);
    dec.sp_base = (word[9:5] == ZR_IDX);
  end
endmodule

// File: rtl/asu_seq.sv
module asu_seq
  import asu_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int SP_ALIGN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  swap_dec_t       dec_in,
  input  logic [XLEN-1:0] base_in,
  input  logic [XLEN-1:0] store_in,
  output logic            idle,
  output logic            req_valid,
  input  logic            req_ready,
  output logic            req_write,
  output logic [XLEN-1:0] req_addr,
  output logic [XLEN-1:0] req_wdata,
  output logic            lock,
  input  logic            rsp_valid,
  input  logic [XLEN-1:0] rsp_data,
  output logic            fin,
  output swap_dec_t       dec_q,
  output logic [XLEN-1:0] load_q,
  output logic            fault_q
);
  localparam int ALW  = $clog2(SP_ALIGN);
  localparam int HALF = XLEN / 2;

  swap_state_e     st;
  logic [XLEN-1:0] base_q, store_q;
  logic            misalign;

  assign misalign = dec_in.sp_base && (base_in[ALW-1:0] != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      dec_q   <= '0;
      base_q  <= '0;
      store_q <= '0;
      load_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          dec_q   <= dec_in;
          base_q  <= base_in;
          store_q <= dec_in.dword ? store_in : {{HALF{1'b0}}, store_in[HALF-1:0]};
          load_q  <= '0;
          fault_q <= dec_in.legal && misalign;
          st      <= (dec_in.legal && !misalign) ? S_RD_REQ : S_DONE;
        end
        S_RD_REQ:  if (req_ready) st <= S_RD_WAIT;
        S_RD_WAIT: if (rsp_valid) begin
          load_q <= dec_q.dword ? rsp_data : {{HALF{1'b0}}, rsp_data[HALF-1:0]};
          st     <= S_WR_REQ;
        end
        S_WR_REQ:  if (req_ready) st <= S_WR_WAIT;
        S_WR_WAIT: if (rsp_valid) st <= S_DONE;
        S_DONE:    st <= S_IDLE;
        default:   st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    idle      = (st == S_IDLE);
    fin       = (st == S_DONE);
    req_valid = (st == S_RD_REQ) || (st == S_WR_REQ);
    req_write = (st == S_WR_REQ);
    lock      = (st == S_RD_REQ) || (st == S_RD_WAIT) ||
                (st == S_WR_REQ) || (st == S_WR_WAIT);
    req_addr  = base_q;
    req_wdata = store_q;
  end
endmodule

// File: rtl/atomic_swap_unit.sv
module atomic_swap_unit
  import asu_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int SP_ALIGN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            insn_valid,
  output logic            insn_ready,
  input  logic [31:0]     insn_word,
  output logic [4:0]      rs_idx,
  input  logic [XLEN-1:0] rs_data,
  output logic [4:0]      rn_idx,
  input  logic [XLEN-1:0] rn_data,
  input  logic [XLEN-1:0] sp_value,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_write,
  output logic            mem_req_dword,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic            mem_lock,
  input  logic            mem_rsp_valid,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            done,
  output logic            rd_we,
  output logic [4:0]      rd_idx,
  output logic [XLEN-1:0] rd_data,
  output logic            acq_flag,
  output logic            rel_flag,
  output logic            tag_chk,
  output logic            align_fault,
  output logic            undef_insn
);
  swap_dec_t       dec_now, dec_q;
  logic [XLEN-1:0] base_sel, load_q;
  logic            idle, fault_q, fin;

  asu_decode u_dec (.word(insn_word), .dec(dec_now));

  assign rs_idx   = dec_now.rs;
  assign rn_idx   = dec_now.rn;
  assign base_sel = dec_now.sp_base ? sp_value : rn_data;

  asu_seq #(.XLEN(XLEN), .SP_ALIGN(SP_ALIGN)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(insn_valid && idle),
    .dec_in(dec_now), .base_in(base_sel), .store_in(rs_data),
    .idle(idle),
    .req_valid(mem_req_valid), .req_ready(mem_req_ready),
    .req_write(mem_req_write), .req_addr(mem_addr), .req_wdata(mem_wdata),
    .lock(mem_lock), .rsp_valid(mem_rsp_valid), .rsp_data(mem_rdata),
    .fin(fin), .dec_q(dec_q), .load_q(load_q), .fault_q(fault_q)
  );

  assign insn_ready    = idle;
  assign mem_req_dword = dec_q.dword;
  assign done          = fin;
  assign undef_insn    = !dec_q.legal;
  assign align_fault   = fault_q;
  assign acq_flag      = dec_q.acq;
  assign rel_flag      = dec_q.rel;
  assign tag_chk       = !dec_q.sp_base;
  assign rd_idx        = dec_q.rt;
  assign rd_data       = load_q;
  assign rd_we         = fin && dec_q.legal && !fault_q && (dec_q.rt != ZR_IDX);
endmodule

// File: rtl/asu_checker.sv
module asu_checker #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            insn_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic            mem_req_write,
  input logic [XLEN-1:0] mem_addr,
  input logic            mem_lock,
  input logic            done,
  input logic            rd_we,
  input logic [4:0]      rd_idx,
  input logic            undef_insn,
  input logic            align_fault
);
  logic [XLEN-1:0] rd_addr_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) rd_addr_seen <= '0;
    else if (mem_req_valid && mem_req_ready && !mem_req_write) rd_addr_seen <= mem_addr;
  end

  a_r9_lock_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> mem_lock);
  a_r9_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && mem_req_write) |-> (mem_addr == rd_addr_seen));
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_addr) && $stable(mem_req_write)));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    insn_ready |-> (!mem_req_valid && !mem_lock));
  a_r7_we_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> done);
  a_r8_no_zr_write: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> (rd_idx != 5'd31));
  a_r1_undef_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (undef_insn || align_fault)) |-> !rd_we);
endmodule

bind atomic_swap_unit asu_checker #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .insn_ready(insn_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_addr(mem_addr), .mem_lock(mem_lock),
  .done(done), .rd_we(rd_we), .rd_idx(rd_idx),
  .undef_insn(undef_insn), .align_fault(align_fault)
);

// File: tb/atomic_swap_unit_test.sv
module atomic_swap_unit_test;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic        insn_valid = 0, insn_ready;
  logic [31:0] insn_word = '0;
  logic [4:0]  rs_idx, rn_idx, rd_idx;
  logic [63:0] rs_data, rn_data, sp_value = '0;
  logic        mem_req_valid, mem_req_ready = 0, mem_req_write, mem_req_dword, mem_lock;
  logic [63:0] mem_addr, mem_wdata, mem_rdata = '0, rd_data;
  logic        mem_rsp_valid = 0;
  logic        done, rd_we, acq_flag, rel_flag, tag_chk, align_fault, undef_insn;

  logic [63:0] regs [32];
  logic [63:0] mem  [16];
  int n_checks = 0, n_errors = 0, n_rd = 0, n_wr = 0, cyc = 0;
  logic [63:0] rd_a, wr_a, wr_d;
  logic        wr_dw;

  assign rs_data = regs[rs_idx];
  assign rn_data = regs[rn_idx];

  atomic_swap_unit uut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      if (mem_req_write) begin
        n_wr++; wr_a = mem_addr; wr_d = mem_wdata; wr_dw = mem_req_dword;
        if (mem_req_dword) mem[mem_addr[6:3]] = mem_wdata;
        else if (mem_addr[2]) mem[mem_addr[6:3]][63:32] = mem_wdata[31:0];
        else mem[mem_addr[6:3]][31:0] = mem_wdata[31:0];
      end else begin
        n_rd++; rd_a = mem_addr;
        if (mem_req_dword) mem_rdata <= mem[mem_addr[6:3]];
        else mem_rdata <= {$urandom(), (mem_addr[2] ? mem[mem_addr[6:3]][63:32]
                                                    : mem[mem_addr[6:3]][31:0])};
      end
    end
    if (rd_we) regs[rd_idx] <= rd_data;
  end

  always @(negedge clk) mem_req_ready <= ($urandom_range(0, 3) != 0);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit dw, input bit a, input bit r,
                                     input logic [4:0] s, input logic [4:0] n, input logic [4:0] t);
    return {1'b1, dw, 6'b111000, a, r, 1'b1, s, 6'b100000, n, t};
  endfunction

  function automatic bit legal_of(input logic [31:0] w);
    return w[31] && (w[29:24] == 6'b111000) && w[21] && (w[15:10] == 6'b100000);
  endfunction

  task automatic run(input logic [31:0] w);
    bit lg, dw, spb, flt, ok;
    logic [4:0] s, n, t;
    logic [63:0] addr, old, sval, exp_ld, exp_mem;
    int r0, w0, waitc;
    lg = legal_of(w); dw = w[30]; s = w[20:16]; n = w[9:5]; t = w[4:0];
    spb = (n == 5'd31);
    addr = spb ? sp_value : regs[n];
    flt = lg && spb && (sp_value[3:0] != 0);
    ok = lg && !flt;
    sval = regs[s];
    old = mem[addr[6:3]];
    exp_ld = dw ? old : {32'h0, (addr[2] ? old[63:32] : old[31:0])};
    exp_mem = dw ? sval : (addr[2] ? {sval[31:0], old[31:0]} : {old[63:32], sval[31:0]});
    r0 = n_rd; w0 = n_wr;
    @(negedge clk);
    insn_word = w; insn_valid = 1;
    while (!insn_ready) @(negedge clk);
    @(posedge clk); #1 insn_valid = 0;
    waitc = 0;
    do begin @(negedge clk); waitc++; end while (!done && waitc < 200);
    chk("R10 done seen", done, 1);
    chk("R1 undef flag", undef_insn, !lg);
    if (!lg) begin
      chk("R1 no access", n_rd + n_wr - r0 - w0, 0);
      chk("R1 no reg write", rd_we, 0);
      return;
    end
    chk("R3 release", rel_flag, w[22]);
    chk("R3 acquire", acq_flag, w[23] && (t != 5'd31));
    chk("R4 tag check", tag_chk, !spb);
    chk("R5 align fault", align_fault, flt);
    if (flt) begin
      chk("R5 no access", n_rd + n_wr - r0 - w0, 0);
      chk("R5 no reg write", rd_we, 0);
      return;
    end
    chk("R9 one read", n_rd - r0, 1);
    chk("R9 one write", n_wr - w0, 1);
    chk("R4 read addr", rd_a, addr);
    chk("R9 write addr", wr_a, addr);
    chk("R2 size", wr_dw, dw);
    chk("R6 write data", wr_d, dw ? sval : {32'h0, sval[31:0]});
    chk("R6 memory after", mem[addr[6:3]], exp_mem);
    chk("R8 reg write", rd_we, t != 5'd31);
    chk("R7 rd idx", rd_idx, t);
    chk("R7 rd data", rd_data, exp_ld);
    @(negedge clk);
    chk("R10 done pulse", done, 0);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) regs[i] = rnd64();
    regs[31] = '0;
    for (int i = 0; i < 16; i++) mem[i] = rnd64();
    repeat (3) @(negedge clk);
    chk("R10 reset ready", insn_ready, 1);
    chk("R10 reset done", done, 0);
    chk("R9 reset lock", mem_lock, 0);
    rst_n = 1;
    // directed corners
    regs[3] = 64'h40; regs[4] = 64'hDEAD_BEEF_1234_5678;
    run(mk(1, 1, 1, 5'd4, 5'd3, 5'd7));            // R2 dword, acq+rel
    regs[3] = 64'h44;
    run(mk(0, 0, 0, 5'd4, 5'd3, 5'd8));            // R7 word, upper half zero
    run(mk(0, 1, 0, 5'd4, 5'd3, 5'd31));           // R8 rt 31, R3 acq off
    sp_value = 64'h20;
    run(mk(1, 0, 1, 5'd4, 5'd31, 5'd9));           // R4 sp base
    sp_value = 64'h28;
    run(mk(1, 0, 0, 5'd4, 5'd31, 5'd9));           // R5 misaligned sp
    run(32'h78A0_8000);                            // R1 bit 31 clear
    run(mk(1, 0, 0, 5'd4, 5'd3, 5'd2) ^ 32'h0000_0400); // R1 bad fixed bit
    // constrained random
    for (int k = 0; k < 60; k++) begin
      logic [4:0] s, n, t;
      logic [31:0] w;
      bit dw;
      s = 5'($urandom_range(0, 31)); n = 5'($urandom_range(0, 31)); t = 5'($urandom_range(0, 31));
      dw = 1'($urandom_range(0, 1));
      if (n != 31) regs[n] = {57'h0, 4'($urandom_range(0, 15)), (dw ? 1'b0 : 1'($urandom_range(0, 1))), 2'b00};
      else sp_value = {57'h0, 3'($urandom_range(0, 7)), ($urandom_range(0, 4) == 0 ? 4'h8 : 4'h0)};
      if (s != 31 && s != n) regs[s] = rnd64();
      w = mk(dw, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), s, n, t);
      if ($urandom_range(0, 9) == 0) w ^= 32'(1) << $urandom_range(10, 15);
      run(w);
    end
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule